// File: doc/BRIEF.md
# Fixed-Length Packet Transmit Framer

This block builds an outgoing radio packet and sends it out as a serial bitstream. A host first loads payload bytes into an internal byte FIFO. It then sets the framing configuration and pulses `start`. The framer sends the packet in this order:

1. a run of 0xAA preamble bytes;
2. a programmable network sync word;
3. an optional node address byte;
4. the payload bytes taken from the FIFO;
5. an optional CRC-16-CCITT checksum.

The modulator provides a bit-clock enable. The framer moves forward by one bit on each pulse, most significant bit first.

Packet handling is gated by a two-bit radio mode field and a length-format select bit. Only fixed-length framing is handled. The programmed payload length counts the node address byte when that byte is enabled. When the packet ends, a sticky stop flag is raised. If the FIFO runs dry while a payload byte is due, the packet is abandoned and a sticky underflow flag is raised instead. A shared interrupt line reports either the stop flag or the FIFO-full flag, chosen by a select input.

Top module: `pkt_tx_framer`

## Requirements
- R1: `start` is accepted only while idle, and only when `radio_mode` is 2'b10 or 2'b11. With `radio_mode` 2'b00 or 2'b01 the framer stays idle (`tx_active`=0, `tx_bit`=0).
- R2: While `len_var_sel`=1 (variable-length format), `start` is ignored and the framer stays idle.
- R3: The preamble is `pre_len`+1 bytes of 0xAA. The sync part that follows is `sync_len`+1 bytes. The first sync byte is `sync_word[8*sync_len+7 -: 8]` and the last is `sync_word[7:0]`.
- R4: Bits go out most significant bit first. `tx_bit` shows the current bit and moves to the next bit only on a cycle with `bit_en`=1. The first preamble bit appears in the cycle after `start` is accepted.
- R5: `pay_len` counts the node address byte and the data bytes together. With `addr_en`=1 and `pay_len`≥1, `node_addr` is sent first, followed by `pay_len`-1 FIFO bytes. With `pay_len`=0, neither an address byte nor data bytes are sent.
- R6: A `pay_len` larger than the FIFO depth (64) is treated as 64.
- R7: With `crc_en`=1, two checksum bytes follow the payload, high byte first. The checksum is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB first over the address and data bytes only.
- R8: After the bit_en pulse that shifts out the last packet bit, `tx_active` falls and `tx_stop` is 1. `tx_stop` stays set until the next accepted `start` clears it.
- R9: `irq1` equals `tx_stop` when `irq_sel`=1 and equals `fifo_full` when `irq_sel`=0.
- R10: If a data byte is due and the FIFO is empty, the framer returns to idle with `underflow`=1 and `tx_stop`=0. `underflow` is cleared by the next accepted `start`.
- R11: `fifo_full` is 1 once 64 bytes are held. A write while full is dropped, so the dropped byte is never transmitted.
- R12: A `start` pulse during a packet, or a change to the framing inputs during a packet, has no effect on the packet in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| radio_mode | input | 2 | Operating mode; 2'b1x enables packet handling |
| len_var_sel | input | 1 | Length format select; 0 = fixed length |
| pay_len | input | 7 | Payload length in bytes, address byte included |
| addr_en | input | 1 | Send node address byte |
| node_addr | input | 8 | Node address value |
| crc_en | input | 1 | Append two-byte checksum |
| pre_len | input | 2 | Preamble bytes minus one |
| sync_len | input | 2 | Sync bytes minus one |
| sync_word | input | 32 | Sync pattern, right-aligned |
| irq_sel | input | 1 | Interrupt source: 1 = stop, 0 = FIFO full |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | FIFO write byte |
| start | input | 1 | Begin a packet |
| bit_en | input | 1 | Bit-clock enable |
| tx_bit | output | 1 | Serial output bit |
| tx_active | output | 1 | Packet in progress |
| tx_stop | output | 1 | Sticky packet-done flag |
| underflow | output | 1 | Sticky FIFO-underflow abort flag |
| fifo_full | output | 1 | FIFO holds 64 bytes |
| irq1 | output | 1 | Selected interrupt line |

## Verification
The bench sweeps every preamble and sync size under all address and checksum settings. This exposes a framer that miscounts a field by one byte or sends the sync word in the wrong byte order. The length sweep covers the payload lengths 0, 1 and 2, the values at and beyond the FIFO depth, and the case where the address byte is the whole payload. A design that gets these wrong either sends an extra data byte, skips the address, or drains a FIFO byte too many. Further runs cover a FIFO that empties part-way through a packet, a write to a full FIFO, and a restart with changed configuration in the middle of a packet. A wrong design would then raise the stop flag on an aborted packet, transmit the dropped byte, or restart and re-frame the packet.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [2:0] {
    F_IDLE,
    F_PRE,
    F_SYNC,
    F_ADDR,
    F_DATA,
    F_CRCH,
    F_CRCL
  } field_e;

  localparam logic [7:0]  PRE_BYTE  = 8'hAA;
  localparam logic [15:0] CRC_POLY  = 16'h1021;
  localparam logic [15:0] CRC_SEED  = 16'hFFFF;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push, pull;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push    = wr_en && !full;
  assign pull    = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pull) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (push && !pull) cnt_d = cnt_q + 1'b1;
    else if (pull && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end

endmodule

// File: rtl/txf_crc16.sv
module txf_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import txf_pkg::*;

  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)     crc_d = CRC_SEED;
    else if (upd) crc_d = crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

endmodule

// File: rtl/txf_shifter.sv
module txf_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         step,
  output logic         dout,
  output logic         last
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q, sh_d;
  logic [BW-1:0] bc_q, bc_d;

  always_comb begin
    sh_d = sh_q;
    bc_d = bc_q;
    if (clr) begin
      sh_d = '0;
      bc_d = '0;
    end else if (load) begin
      sh_d = din;
      bc_d = '0;
    end else if (step) begin
      sh_d = {sh_q[W-2:0], 1'b0};
      bc_d = bc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      bc_q <= '0;
    end else begin
      sh_q <= sh_d;
      bc_q <= bc_d;
    end
  end

  assign dout = sh_q[W-1];
  assign last = (bc_q == BW'(W - 1));

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
  parameter int DEPTH      = 64,
  parameter int LEN_W      = 7,
  parameter int PRE_MAX    = 4,
  parameter int SYNC_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              radio_mode,
  input  logic                    len_var_sel,
  input  logic [LEN_W-1:0]        pay_len,
  input  logic                    addr_en,
  input  logic [7:0]              node_addr,
  input  logic                    crc_en,
  input  logic [((PRE_MAX > 1) ? $clog2(PRE_MAX) : 1)-1:0]       pre_len,
  input  logic [((SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1)-1:0] sync_len,
  input  logic [8*SYNC_BYTES-1:0] sync_word,
  input  logic                    irq_sel,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  logic                    start,
  input  logic                    bit_en,
  output logic                    tx_bit,
  output logic                    tx_active,
  output logic                    tx_stop,
  output logic                    underflow,
  output logic                    fifo_full,
  output logic                    irq1
);
  import txf_pkg::*;

  localparam int PW      = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;
  localparam int SW      = (SYNC_BYTES > 1) ? $clog2(SYNC_BYTES) : 1;
  localparam int LEN_MAX = (1 << LEN_W) - 1;
  localparam int LIM     = (DEPTH < LEN_MAX) ? DEPTH : LEN_MAX;

  field_e state_q, state_d, nf, af_sync, af_data;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_in, data_total;
  logic [PW-1:0]    pre_q;
  logic [SW-1:0]    sync_q, sync_sel;
  logic [8*SYNC_BYTES-1:0] syncw_q;
  logic [7:0]       node_q;
  logic             addr_q, crcen_q;
  logic             stop_q, stop_d, ufl_q, ufl_d;
  logic             cfg_ld, stay, mode_ok;
  logic             ld, clr, pop, crc_upd, crc_init;
  logic [7:0]       ld_byte, fifo_dout;
  logic             fifo_empty, last_bit, sh_bit;
  logic [15:0]      crc_val;
  logic [7:0]       sync_bytes [SYNC_BYTES];

  for (genvar g = 0; g < SYNC_BYTES; g++) begin : g_sync
    assign sync_bytes[g] = syncw_q[8*g +: 8];
  end

  txf_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(pop), .rd_data(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  txf_crc16 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .upd(crc_upd),
    .din(ld_byte), .crc(crc_val)
  );

  txf_shifter #(.W(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(ld), .din(ld_byte),
    .step(bit_en && tx_active), .dout(sh_bit), .last(last_bit)
  );

  assign mode_ok    = radio_mode[1] && !len_var_sel;
  assign len_in     = (pay_len > LEN_W'(LIM)) ? LEN_W'(LIM) : pay_len;
  assign data_total = (addr_q && len_q != '0) ? len_q - 1'b1 : len_q;
  assign af_data    = crcen_q ? F_CRCH : F_IDLE;
  assign af_sync    = (len_q == '0) ? af_data : (addr_q ? F_ADDR : F_DATA);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    nf       = F_IDLE;
    stay     = 1'b0;
    ld       = 1'b0;
    ld_byte  = '0;
    clr      = 1'b0;
    pop      = 1'b0;
    crc_upd  = 1'b0;
    crc_init = 1'b0;
    cfg_ld   = 1'b0;
    stop_d   = stop_q;
    ufl_d    = ufl_q;
    sync_sel = '0;
    if (state_q == F_IDLE) begin
      if (start && mode_ok) begin
        state_d  = F_PRE;
        cnt_d    = '0;
        ld       = 1'b1;
        ld_byte  = PRE_BYTE;
        crc_init = 1'b1;
        cfg_ld   = 1'b1;
        stop_d   = 1'b0;
        ufl_d    = 1'b0;
      end
    end else if (bit_en && last_bit) begin
      unique case (state_q)
        F_PRE: begin
          stay = (cnt_q < LEN_W'(pre_q));
          nf   = stay ? F_PRE : F_SYNC;
        end
        F_SYNC: begin
          stay = (cnt_q < LEN_W'(sync_q));
          nf   = stay ? F_SYNC : af_sync;
        end
        F_ADDR: nf = (data_total == '0) ? af_data : F_DATA;
        F_DATA: begin
          stay = ((cnt_q + 1'b1) < data_total);
          nf   = stay ? F_DATA : af_data;
        end
        F_CRCH: nf = F_CRCL;
        default: nf = F_IDLE;
      endcase
      cnt_d    = stay ? cnt_q + 1'b1 : '0;
      state_d  = nf;
      sync_sel = sync_q - cnt_d[SW-1:0];
      unique case (nf)
        F_PRE: begin
          ld      = 1'b1;
          ld_byte = PRE_BYTE;
        end
        F_SYNC: begin
          ld      = 1'b1;
          ld_byte = sync_bytes[sync_sel];
        end
        F_ADDR: begin
          ld      = 1'b1;
          ld_byte = node_q;
          crc_upd = 1'b1;
        end
        F_DATA: begin
          if (fifo_empty) begin
            state_d = F_IDLE;
            ufl_d   = 1'b1;
            clr     = 1'b1;
          end else begin
            ld      = 1'b1;
            pop     = 1'b1;
            ld_byte = fifo_dout;
            crc_upd = 1'b1;
          end
        end
        F_CRCH: begin
          ld      = 1'b1;
          ld_byte = crc_val[15:8];
        end
        F_CRCL: begin
          ld      = 1'b1;
          ld_byte = crc_val[7:0];
        end
        default: begin
          clr    = 1'b1;
          stop_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= F_IDLE;
      cnt_q   <= '0;
      stop_q  <= 1'b0;
      ufl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      stop_q  <= stop_d;
      ufl_q   <= ufl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      pre_q   <= '0;
      sync_q  <= '0;
      syncw_q <= '0;
      node_q  <= '0;
      addr_q  <= 1'b0;
      crcen_q <= 1'b0;
    end else if (cfg_ld) begin
      len_q   <= len_in;
      pre_q   <= pre_len;
      sync_q  <= sync_len;
      syncw_q <= sync_word;
      node_q  <= node_addr;
      addr_q  <= addr_en;
      crcen_q <= crc_en;
    end
  end

  assign tx_active = (state_q != F_IDLE);
  assign tx_bit    = tx_active && sh_bit;
  assign tx_stop   = stop_q;
  assign underflow = ufl_q;
  assign irq1      = irq_sel ? stop_q : fifo_full;

endmodule

// File: rtl/txf_checker.sv
module txf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] radio_mode,
  input logic       len_var_sel,
  input logic       bit_en,
  input logic       tx_bit,
  input logic       tx_active,
  input logic       tx_stop,
  input logic       underflow,
  input logic       fifo_full
);

  // R1
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !radio_mode[1]) |=> !tx_active);

  // R2
  var_fmt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && len_var_sel) |=> !tx_active);

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !bit_en) |=> $stable(tx_bit));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> !tx_bit);

  // R8
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_active) |-> (tx_stop != underflow));

  // R10
  abort_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> !tx_stop);

  // R11
  full_held_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !tx_active) |=> fifo_full);

endmodule

bind pkt_tx_framer txf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .radio_mode(radio_mode), .len_var_sel(len_var_sel),
  .bit_en(bit_en), .tx_bit(tx_bit), .tx_active(tx_active), .tx_stop(tx_stop),
  .underflow(underflow), .fifo_full(fifo_full)
);

// File: tb/pkt_tx_framer_test.sv
module pkt_tx_framer_test;
  localparam int DEPTH = 64;

  logic        clk, rst_n;
  logic [1:0]  radio_mode;
  logic        len_var_sel, addr_en, crc_en, irq_sel, wr_en, start, bit_en;
  logic [6:0]  pay_len;
  logic [7:0]  node_addr, wr_data;
  logic [1:0]  pre_len, sync_len;
  logic [31:0] sync_word;
  logic        tx_bit, tx_active, tx_stop, underflow, fifo_full, irq1;

  int tests, fails, seed;
  bit done;
  logic [7:0] exp_b [0:255];

  pkt_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .radio_mode(radio_mode), .len_var_sel(len_var_sel),
    .pay_len(pay_len), .addr_en(addr_en), .node_addr(node_addr), .crc_en(crc_en),
    .pre_len(pre_len), .sync_len(sync_len), .sync_word(sync_word), .irq_sel(irq_sel),
    .wr_en(wr_en), .wr_data(wr_data), .start(start), .bit_en(bit_en),
    .tx_bit(tx_bit), .tx_active(tx_active), .tx_stop(tx_stop), .underflow(underflow),
    .fifo_full(fifo_full), .irq1(irq1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] dval(input int i);
    return 8'((i * 29 + 7 + seed * 13) & 255);
  endfunction

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      if (r[15] ^ b[k]) r = (r << 1) ^ 16'h1021;
      else              r = r << 1;
    end
    return r;
  endfunction

  task automatic write_fifo(input logic [7:0] v);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_pkt(input int len, input bit a, input bit c, input int pre,
                         input int syn, input int avail, input bit load,
                         input bit poke, input bit [1:0] om, input string tag);
    int eff, dt, nsent, n, mism;
    bit uf;
    logic [15:0] crc;
    eff = (len > DEPTH) ? DEPTH : len;
    dt  = (a && eff > 0) ? eff - 1 : eff;
    uf  = (dt > avail);
    radio_mode = om; len_var_sel = 1'b0; pay_len = 7'(len);
    addr_en = a; crc_en = c; pre_len = 2'(pre); sync_len = 2'(syn);
    node_addr = 8'(8'h5C ^ seed); irq_sel = 1'b1;
    if (load) for (int i = 0; i < avail; i++) write_fifo(dval(i));
    n = 0;
    crc = 16'hFFFF;
    for (int p = 0; p <= pre; p++) begin exp_b[n] = 8'hAA; n++; end
    for (int k = 0; k <= syn; k++) begin exp_b[n] = sync_word[8*(syn-k) +: 8]; n++; end
    if (a && eff > 0) begin exp_b[n] = node_addr; crc = crc_b(crc, node_addr); n++; end
    nsent = uf ? avail : dt;
    for (int i = 0; i < nsent; i++) begin exp_b[n] = dval(i); crc = crc_b(crc, dval(i)); n++; end
    if (!uf && c) begin exp_b[n] = crc[15:8]; exp_b[n+1] = crc[7:0]; n += 2; end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: accepted start clears the sticky flags
    chk(tx_active && !tx_stop && !underflow, "R8 start clears flags", int'(tx_stop), 0);
    mism = 0;
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (tx_bit !== exp_b[b][i]) mism++;
        if (poke && b == 2 && i == 3) begin
          start = 1'b1; pay_len = 7'd3; crc_en = ~c;
          @(negedge clk);
          start = 1'b0;
        end
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
      end
    end
    chk(mism == 0, tag, mism, 0);
    chk(!tx_active, "R8 idle after last bit", int'(tx_active), 0);
    chk(tx_stop == !uf, uf ? "R10 no stop on abort" : "R8 stop flag", int'(tx_stop), int'(!uf));
    chk(underflow == uf, "R10 underflow flag", int'(underflow), int'(uf));
    chk(irq1 == tx_stop, "R9 irq1 follows stop", int'(irq1), int'(tx_stop));
    seed++;
  endtask

  task automatic try_blocked(input bit [1:0] om, input bit vs, input string tag);
    radio_mode = om; len_var_sel = vs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!tx_active && !tx_bit, tag, int'(tx_active), 0);
    len_var_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; seed = 0; done = 0;
    rst_n = 1'b0; radio_mode = 2'b00; len_var_sel = 1'b0; pay_len = '0;
    addr_en = 1'b0; node_addr = '0; crc_en = 1'b0; pre_len = '0; sync_len = '0;
    sync_word = 32'hD391_7E2B; irq_sel = 1'b1; wr_en = 1'b0; wr_data = '0;
    start = 1'b0; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_active && !tx_bit && !tx_stop && !underflow && !fifo_full,
        "R1 reset state idle", int'(tx_active), 0);

    // R1 / R2: gated modes and the variable-length format leave it idle
    try_blocked(2'b00, 1'b0, "R1 mode 00 ignored");
    try_blocked(2'b01, 1'b0, "R1 mode 01 ignored");
    try_blocked(2'b10, 1'b1, "R2 var format ignored");
    try_blocked(2'b11, 1'b1, "R2 var format ignored mode 11");

    // R3 / R4: sweep of preamble, sync, address and CRC settings
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int ac = 0; ac < 4; ac++)
          run_pkt((p * 4 + s + ac) % 5, ac[0], ac[1], p, s,
                  (((p * 4 + s + ac) % 5) > 0 && ac[0]) ? ((p * 4 + s + ac) % 5) - 1 : (p * 4 + s + ac) % 5,
                  1'b1, 1'b0, (s[0]) ? 2'b11 : 2'b10, "R3 field order R4 bit order");

    // R5: length counts the address byte
    run_pkt(0, 1, 1, 1, 1, 0, 1'b1, 1'b0, 2'b10, "R5 zero length no address");
    run_pkt(1, 1, 0, 0, 0, 0, 1'b1, 1'b0, 2'b10, "R5 address only");
    run_pkt(2, 1, 1, 0, 1, 1, 1'b1, 1'b0, 2'b11, "R5 address plus one");
    run_pkt(63, 1, 1, 2, 3, 62, 1'b1, 1'b0, 2'b10, "R7 long with crc");
    run_pkt(64, 0, 1, 3, 0, 64, 1'b1, 1'b0, 2'b10, "R6 length at depth");

    // R11 / R9: fill, overfill, then R6 clamp drains exactly the depth
    irq_sel = 1'b0;
    for (int i = 0; i <= DEPTH; i++) write_fifo(dval(i));
    chk(fifo_full == 1'b1, "R11 full after depth writes", int'(fifo_full), 1);
    chk(irq1 == 1'b1, "R9 irq1 follows full", int'(irq1), 1);
    run_pkt(100, 0, 1, 0, 2, 64, 1'b0, 1'b0, 2'b10, "R6 clamp R11 dropped write");
    irq_sel = 1'b0;
    @(negedge clk);
    chk(fifo_full == 1'b0 && irq1 == 1'b0, "R11 FIFO drained", int'(fifo_full), 0);

    // R10: FIFO runs dry
    run_pkt(6, 0, 1, 0, 0, 2, 1'b1, 1'b0, 2'b10, "R10 abort stream");
    run_pkt(3, 1, 1, 1, 0, 0, 1'b1, 1'b0, 2'b11, "R10 abort after address");

    // R12: restart and config change mid-packet
    run_pkt(5, 1, 1, 1, 1, 4, 1'b1, 1'b1, 2'b10, "R12 mid-packet start ignored");
    run_pkt(2, 0, 0, 0, 0, 2, 1'b1, 1'b0, 2'b10, "R12 next packet normal");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule